// File: doc/BRIEF.md
# Register-Mapped Reconfiguration Port Bridge

This block sits between a host processor's 32-bit register bus and the dynamic reconfiguration port (DRP) of a clock synthesizer. It lets software reprogram the synthesizer's internal configuration words. The host sees four registers. The first is a control word that releases the synthesizer's reset and enables it. The second selects which of the parent clocks feeds the synthesizer. The third is a command word, and the fourth reports completion and returns read data.

A single host write to the command register starts a whole port transaction. The write carries the target port address, the write data, a start flag and a read flag. The bridge issues a one-cycle enable on the port and raises a busy flag. It then waits for the port's ready pulse. After a read, the returned word is latched into the status register. Software polls busy until it clears before it issues the next command, and polls it again after a read before it takes the data. The block performs no frequency calculation and contains no part of the synthesizer itself.

Top module: `drp_reg_bridge`

## Requirements
- R1: After reset, every register reads zero, `synth_release`, `synth_enable` and `clk_sel` are 0, the port enable and write-enable are low, and busy (status bit 16) is clear.
- R2: The register at byte offset 0x40 is read/write. Its bit 0 drives `synth_release` and its bit 1 drives `synth_enable`. Both take effect in the cycle after the write.
- R3: The register at offset 0x44 is read/write. Its low bit selects the parent clock and drives `clk_sel` in the cycle after the write.
- R4: A write to offset 0x70 with bit 29 set and bit 28 clear starts a port write. In the cycle after the host write, `drp_en` and `drp_we` are high for exactly one cycle. `drp_addr` equals bits 22:16 and `drp_di` equals bits 15:0.
- R5: A write to offset 0x70 with bits 29 and 28 both set starts a port read. `drp_en` pulses for one cycle with `drp_we` low. The `drp_do` value present with the ready pulse then appears in bits 15:0 of offset 0x74.
- R6: Busy (offset 0x74, bit 16) rises in the cycle after an accepted command. It stays high until `drp_rdy` is seen and is low in the cycle after the ready pulse.
- R7: A write to offset 0x70 while busy is high has no effect. No new port enable is issued, and the command readback at offset 0x70 still shows the in-flight command: bit 28 is the read flag, bits 22:16 the address and bits 15:0 the data.
- R8: A write to offset 0x70 with bit 29 clear starts nothing and leaves busy low.
- R9: A `drp_rdy` pulse while idle leaves the status read data unchanged.
- R10: Host read data appears on `bus_rdata` in the cycle after `bus_rd_en`. Unmapped offsets read as zero.
- R11: A completed port write leaves the status read data from the last port read unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Host write strobe |
| bus_rd_en | input | 1 | Host read strobe |
| bus_addr | input | 8 | Host byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| synth_release | output | 1 | Releases synthesizer reset |
| synth_enable | output | 1 | Enables the synthesizer |
| clk_sel | output | 1 | Parent clock select |
| drp_addr | output | 7 | Port register address |
| drp_di | output | 16 | Port write data |
| drp_do | input | 16 | Port read data |
| drp_en | output | 1 | Port enable pulse |
| drp_we | output | 1 | Port write-enable |
| drp_rdy | input | 1 | Port ready pulse |

## Verification
Every result is due exactly one clock after its cause. The port enable, write-enable, address and data follow the host command write by one edge. Busy rises on that same edge and falls one edge after the ready pulse. A register read returns on the edge after the read strobe, so a busy value read back reflects the state at the read edge. The bench drives inputs and samples outputs on the falling clock edge. It checks the port strobes on the falling edge right after the command write and checks that they have dropped one falling edge later. It reads busy and read data back through the status register at known offsets from the command and the ready pulse.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

  // Host register byte offsets
  localparam int unsigned OFF_CTRL   = 32'h40;
  localparam int unsigned OFF_CLKSEL = 32'h44;
  localparam int unsigned OFF_CMD    = 32'h70;
  localparam int unsigned OFF_STAT   = 32'h74;

  // Control register bits
  localparam int unsigned BIT_RELEASE = 0;
  localparam int unsigned BIT_ENABLE  = 1;

  // Command word fields
  localparam int unsigned BIT_START   = 29;
  localparam int unsigned BIT_READ    = 28;
  localparam int unsigned ADDR_LSB    = 16;

  // Status word fields
  localparam int unsigned BIT_BUSY    = 16;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;

endpackage

// File: rtl/drp_host_regs.sv
module drp_host_regs
  import drp_bridge_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned SEL_W  = 1,
  parameter int unsigned DRP_AW = 7,
  parameter int unsigned DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              ctrl_release,
  output logic              ctrl_enable,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              cmd_strobe,
  input  logic              st_busy,
  input  logic [DRP_DW-1:0] st_rdata,
  input  logic              cmd_rd,
  input  logic [DRP_AW-1:0] cmd_addr,
  input  logic [DRP_DW-1:0] cmd_data
);

  localparam logic [AW-1:0] A_CTRL   = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_CLKSEL = AW'(OFF_CLKSEL);
  localparam logic [AW-1:0] A_CMD    = AW'(OFF_CMD);
  localparam logic [AW-1:0] A_STAT   = AW'(OFF_STAT);

  logic             release_q, release_d;
  logic             enable_q,  enable_d;
  logic [SEL_W-1:0] sel_q,     sel_d;
  logic [DW-1:0]    rdata_q,   rdata_d;
  logic             ctrl_we, sel_we;
  logic [DW-1:0]    rd_word;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  // write decode
  always_comb begin
    ctrl_we    = bus_wr_en && (bus_addr == A_CTRL);
    sel_we     = bus_wr_en && (bus_addr == A_CLKSEL);
    cmd_strobe = bus_wr_en && (bus_addr == A_CMD);
    release_d  = bus_wdata[BIT_RELEASE];
    enable_d   = bus_wdata[BIT_ENABLE];
    sel_d      = bus_wdata[SEL_W-1:0];
  end

  // read mux
  always_comb begin
    rd_word = '0;
    unique case (bus_addr)
      A_CTRL: begin
        rd_word[BIT_RELEASE] = release_q;
        rd_word[BIT_ENABLE]  = enable_q;
      end
      A_CLKSEL: rd_word[SEL_W-1:0] = sel_q;
      A_CMD: begin
        rd_word[BIT_READ]                = cmd_rd;
        rd_word[ADDR_LSB +: DRP_AW]      = cmd_addr;
        rd_word[DRP_DW-1:0]              = cmd_data;
      end
      A_STAT: begin
        rd_word[BIT_BUSY]    = st_busy;
        rd_word[DRP_DW-1:0]  = st_rdata;
      end
      default: rd_word = '0;
    endcase
    rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      enable_q  <= 1'b0;
    end else if (ctrl_we) begin
      release_q <= release_d;
      enable_q  <= enable_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign ctrl_release = release_q;
  assign ctrl_enable  = enable_q;
  assign clk_sel      = sel_q;

endmodule

// File: rtl/drp_sequencer.sv
module drp_sequencer
  import drp_bridge_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned DRP_AW = 7,
  parameter int unsigned DRP_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_strobe,
  input  logic [DW-1:0]     cmd_word,
  output logic              drp_en,
  output logic              drp_we,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  input  logic              drp_rdy,
  output logic              busy,
  output logic [DRP_DW-1:0] rd_data,
  output logic              cmd_rd
);

  seq_state_t        state_q, state_d;
  logic              accept, finish;
  logic              en_q, en_d;
  logic              we_q, we_d;
  logic              rd_q;
  logic [DRP_AW-1:0] addr_q;
  logic [DRP_DW-1:0] di_q;
  logic [DRP_DW-1:0] rdat_q;
  logic              unused_cmd;

  assign unused_cmd = ^cmd_word;

  // next-state
  always_comb begin
    accept  = cmd_strobe && cmd_word[BIT_START] && (state_q == SEQ_IDLE);
    finish  = (state_q == SEQ_WAIT) && drp_rdy;
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (accept) state_d = SEQ_WAIT;
      SEQ_WAIT: if (drp_rdy) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
    en_d = accept;
    we_d = accept && !cmd_word[BIT_READ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      en_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      we_q    <= we_d;
    end
  end

  // command capture, loaded only on an accepted command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
      di_q   <= '0;
    end else if (accept) begin
      rd_q   <= cmd_word[BIT_READ];
      addr_q <= cmd_word[ADDR_LSB +: DRP_AW];
      di_q   <= cmd_word[DRP_DW-1:0];
    end
  end

  // returned data, loaded only when a read completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (finish && rd_q) begin
      rdat_q <= drp_do;
    end
  end

  assign drp_en   = en_q;
  assign drp_we   = we_q;
  assign drp_addr = addr_q;
  assign drp_di   = di_q;
  assign busy     = (state_q == SEQ_WAIT);
  assign rd_data  = rdat_q;
  assign cmd_rd   = rd_q;

endmodule

// File: rtl/drp_reg_bridge.sv
module drp_reg_bridge
  import drp_bridge_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_CLK = 2,
  parameter int unsigned DRP_AW  = 7,
  parameter int unsigned DRP_DW  = 16,
  localparam int unsigned SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              synth_release,
  output logic              synth_enable,
  output logic [SEL_W-1:0]  clk_sel,
  output logic [DRP_AW-1:0] drp_addr,
  output logic [DRP_DW-1:0] drp_di,
  input  logic [DRP_DW-1:0] drp_do,
  output logic              drp_en,
  output logic              drp_we,
  input  logic              drp_rdy
);

  logic              cmd_strobe;
  logic              seq_busy;
  logic [DRP_DW-1:0] seq_rdata;
  logic              seq_cmd_rd;

  drp_host_regs #(
    .AW(AW), .DW(DW), .SEL_W(SEL_W), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ctrl_release (synth_release),
    .ctrl_enable  (synth_enable),
    .clk_sel      (clk_sel),
    .cmd_strobe   (cmd_strobe),
    .st_busy      (seq_busy),
    .st_rdata     (seq_rdata),
    .cmd_rd       (seq_cmd_rd),
    .cmd_addr     (drp_addr),
    .cmd_data     (drp_di)
  );

  drp_sequencer #(
    .DW(DW), .DRP_AW(DRP_AW), .DRP_DW(DRP_DW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_strobe (cmd_strobe),
    .cmd_word   (bus_wdata),
    .drp_en     (drp_en),
    .drp_we     (drp_we),
    .drp_addr   (drp_addr),
    .drp_di     (drp_di),
    .drp_do     (drp_do),
    .drp_rdy    (drp_rdy),
    .busy       (seq_busy),
    .rd_data    (seq_rdata),
    .cmd_rd     (seq_cmd_rd)
  );

endmodule

// File: rtl/drp_reg_bridge_chk.sv
module drp_reg_bridge_chk #(
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32,
  parameter int unsigned DRP_DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              synth_enable,
  input logic              drp_en,
  input logic              drp_we,
  input logic              drp_rdy,
  input logic              busy,
  input logic [DRP_DW-1:0] rd_data
);

  localparam logic [AW-1:0] A_CTRL = AW'(32'h40);

  // R4: port enable is a single-cycle pulse
  a_r4_en_single: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en);

  // R4: write-enable only together with enable
  a_r4_we_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    drp_we |-> drp_en);

  // R6, R7: an enable pulse coincides with busy just rising
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> (busy && !$past(busy)));

  // R6: busy clears right after ready
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && drp_rdy) |=> !busy);

  // R6: busy holds until ready
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drp_rdy) |=> busy);

  // R9: a stray ready while idle leaves read data alone
  a_r9_idle_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && drp_rdy) |=> $stable(rd_data));

  // R2: enable bit follows a control write
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == A_CTRL) |=> (synth_enable == $past(bus_wdata[1])));

endmodule

bind drp_reg_bridge drp_reg_bridge_chk #(
  .AW(AW), .DW(DW), .DRP_DW(DRP_DW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_en    (bus_wr_en),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .synth_enable (synth_enable),
  .drp_en       (drp_en),
  .drp_we       (drp_we),
  .drp_rdy      (drp_rdy),
  .busy         (seq_busy),
  .rd_data      (seq_rdata)
);

// File: tb/drp_reg_bridge_test.sv
module drp_reg_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        synth_release, synth_enable;
  logic [0:0]  clk_sel;
  logic [6:0]  drp_addr;
  logic [15:0] drp_di;
  logic [15:0] drp_do = '0;
  logic        drp_en, drp_we;
  logic        drp_rdy = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  drp_reg_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .synth_release(synth_release), .synth_enable(synth_enable),
    .clk_sel(clk_sel),
    .drp_addr(drp_addr), .drp_di(drp_di), .drp_do(drp_do),
    .drp_en(drp_en), .drp_we(drp_we), .drp_rdy(drp_rdy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ready_pulse(input logic [15:0] d);
    drp_rdy = 1'b1; drp_do = d;
    @(negedge clk);
    drp_rdy = 1'b0; drp_do = 16'h0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 release", 32'(synth_release), 0);
    check("R1 enable", 32'(synth_enable), 0);
    check("R1 clk_sel", 32'(clk_sel), 0);
    check("R1 drp_en", 32'(drp_en), 0);
    check("R1 drp_we", 32'(drp_we), 0);
    host_read(8'h40, v); check("R1 ctrl reg", v, 0);
    host_read(8'h70, v); check("R1 cmd reg", v, 0);
    host_read(8'h74, v); check("R1 status", v, 0);
  endtask

  task automatic t_ctrl_sel;
    logic [31:0] v;
    host_write(8'h40, 32'h1);
    check("R2 release", 32'(synth_release), 1);
    check("R2 enable off", 32'(synth_enable), 0);
    host_write(8'h40, 32'h3);
    check("R2 enable on", 32'(synth_enable), 1);
    host_read(8'h40, v); check("R2 readback", v, 32'h3);
    host_write(8'h44, 32'h1);
    check("R3 clk_sel", 32'(clk_sel), 1);
    host_read(8'h44, v); check("R3 readback", v, 32'h1);
    host_write(8'h44, 32'h0);
    check("R3 clk_sel back", 32'(clk_sel), 0);
  endtask

  task automatic t_read_cmd;
    logic [31:0] v;
    host_write(8'h70, 32'h3015_1234);  // start+read, addr 0x15
    check("R5 drp_en", 32'(drp_en), 1);
    check("R5 drp_we low", 32'(drp_we), 0);
    check("R5 drp_addr", 32'(drp_addr), 32'h15);
    host_read(8'h74, v); check("R6 busy rise", 32'(v[16]), 1);
    check("R5 en single", 32'(drp_en), 0);
    repeat (3) @(negedge clk);
    host_read(8'h74, v); check("R6 busy hold", 32'(v[16]), 1);
    ready_pulse(16'hBEEF);
    host_read(8'h74, v); check("R5 R6 status after read", v, 32'h0000_BEEF);
  endtask

  task automatic t_write_cmd;
    logic [31:0] v;
    host_write(8'h70, 32'h2008_A55A);  // start write, addr 0x08
    check("R4 drp_en", 32'(drp_en), 1);
    check("R4 drp_we", 32'(drp_we), 1);
    check("R4 drp_addr", 32'(drp_addr), 32'h08);
    check("R4 drp_di", 32'(drp_di), 32'hA55A);
    @(negedge clk);
    check("R4 en single", 32'(drp_en), 0);
    check("R4 we single", 32'(drp_we), 0);
    ready_pulse(16'h7777);
    host_read(8'h74, v); check("R11 data kept after write", v, 32'h0000_BEEF);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    host_write(8'h70, 32'h304E_0000);  // read addr 0x4E
    @(negedge clk);
    host_write(8'h70, 32'h2019_1111);  // while busy
    check("R7 no new en", 32'(drp_en), 0);
    @(negedge clk);
    check("R7 no new en later", 32'(drp_en), 0);
    host_read(8'h70, v); check("R7 cmd unchanged", v, 32'h104E_0000);
    check("R7 addr unchanged", 32'(drp_addr), 32'h4E);
    ready_pulse(16'h0C0D);
    host_read(8'h74, v); check("R7 read completes", v, 32'h0000_0C0D);
  endtask

  task automatic t_no_start;
    logic [31:0] v;
    host_write(8'h70, 32'h1022_3333);  // start bit clear
    check("R8 no en", 32'(drp_en), 0);
    host_read(8'h74, v); check("R8 not busy", v, 32'h0000_0C0D);
  endtask

  task automatic t_idle_ready;
    logic [31:0] v;
    ready_pulse(16'hDEAD);
    host_read(8'h74, v); check("R9 idle ready ignored", v, 32'h0000_0C0D);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    host_read(8'h48, v); check("R10 unmapped 0x48", v, 0);
    host_read(8'h00, v); check("R10 unmapped 0x00", v, 0);
    bus_rd_en = 1'b1; bus_addr = 8'h40;
    @(posedge clk); #1;
    check("R10 latency one cycle", bus_rdata, 32'h3);
    @(negedge clk); bus_rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl_sel;
    t_read_cmd;
    t_write_cmd;
    t_busy_ignore;
    t_no_start;
    t_idle_ready;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule